// File: doc/BRIEF.md
# Float to Extended Format Converter

This unit widens an IEEE-754 binary32 or binary64 operand into a wide internal floating-point word. The word has a sign bit, a 15-bit exponent biased by 16383 and a 64-bit significand whose integer bit is stored explicitly at bit 63. A format select picks the source width. The unit splits the source into its fields, moves the exponent onto the wide bias and left-aligns the fraction under the integer bit. It also sorts out the special encodings: zeros, infinities and NaNs, and subnormals.

One conversion is accepted in any cycle where `in_valid` is high. The result appears one clock later, marked by `out_valid`. In cycles without a request the result registers keep their value. The unit does no rounding and does not renormalise subnormal inputs. A subnormal input is passed on with its integer bit clear, and a flag marks it.

Top module: `fext_convert`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was sampled high, and the result of that request is on the outputs in that same cycle.
- R2: With `in_fmt`=0 (binary32) the sign is `in_word[31]`, the exponent field is `in_word[30:23]` and the fraction is `in_word[22:0]`. The bits `in_word[63:32]` have no effect on the result.
- R3: A normal binary32 input gives `out_exp` = field + 16256 and `out_man` = {1, fraction, 40 zero bits}.
- R4: With `in_fmt`=1 (binary64) the sign is bit 63, the exponent field is bits 62:52 and the fraction is bits 51:0. A normal input gives `out_exp` = field + 15360 and `out_man` = {1, fraction, 11 zero bits}.
- R5: An exponent field of all ones (0xFF for binary32, 0x7FF for binary64) gives `out_exp` = 0x7FFF and `out_man` = {1, aligned fraction}, with `out_denorm` low. The fraction is kept, so a NaN payload survives.
- R6: A zero of either sign gives `out_exp` = 0 and `out_man` = 0, keeps the sign, and leaves `out_denorm` low.
- R7: A subnormal input (exponent field zero, fraction nonzero) gives `out_exp` = 0, `out_man` = {0, aligned fraction}, and `out_denorm` high.
- R8: While `rst` is high at a clock edge, every output is driven to zero on that edge.
- R9: In a cycle where `in_valid` is low, `out_sign`, `out_exp`, `out_man` and `out_denorm` keep the values they had.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Conversion request |
| in_fmt | input | 1 | Source format: 0 = binary32 in bits 31:0, 1 = binary64 |
| in_word | input | 64 | Source operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_sign | output | 1 | Result sign |
| out_exp | output | 15 | Result exponent, bias 16383, 0x7FFF marks infinity/NaN |
| out_man | output | 64 | Result significand, explicit integer bit at bit 63 |
| out_denorm | output | 1 | Source was subnormal |

## Verification
Each step of the conversion shows up directly at the outputs one cycle after the request, so a fault in it is visible at once:

- A wrong field split shows as a shifted significand or a wrong exponent.
- A wrong bias offset shifts every normal exponent by a constant amount.
- A mistake in the special-case decode shows as a set integer bit on a zero or subnormal result, or as a finite exponent where 0x7FFF is expected.
- Stale or leaking result registers show when `in_valid` is low: idle cycles with changing inputs make any update visible in the very next cycle.

// File: rtl/fext_pkg.sv
package fext_pkg;

    // Wide format geometry
    localparam int EXT_EXP_W = 15;
    localparam int EXT_MAN_W = 64;
    localparam int EXT_BIAS  = (1 << (EXT_EXP_W - 1)) - 1;
    localparam logic [EXT_EXP_W-1:0] EXT_EXP_SPECIAL = '1;

    // Source formats
    localparam int NUM_FMT = 2;
    localparam int SRC_W   = 64;
    localparam int FRAC_AL_W = EXT_MAN_W - 1;

    typedef enum logic {
        FMT_BIN32 = 1'b0,
        FMT_BIN64 = 1'b1
    } src_fmt_e;

    function automatic int fmt_exp_w(int idx);
        return (idx == 0) ? 8 : 11;
    endfunction

    function automatic int fmt_frac_w(int idx);
        return (idx == 0) ? 23 : 52;
    endfunction

    // Classified source fields
    typedef struct packed {
        logic                 sign;
        logic                 exp_all_ones;
        logic                 exp_is_zero;
        logic                 frac_nonzero;
        logic [EXT_EXP_W-1:0] exp_rebiased;
        logic [FRAC_AL_W-1:0] frac_aligned;
    } src_fields_t;

    // Wide result word
    typedef struct packed {
        logic                 sign;
        logic [EXT_EXP_W-1:0] exponent;
        logic [EXT_MAN_W-1:0] mantissa;
        logic                 denorm;
    } ext_word_t;

    function automatic logic [EXT_EXP_W-1:0] rebias(logic [EXT_EXP_W-1:0] field_val,
                                                     int                   offset);
        return field_val + EXT_EXP_W'(offset);
    endfunction

endpackage

// File: rtl/fext_unpack.sv
module fext_unpack
    import fext_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] raw,
    output src_fields_t           fields
);
    localparam int SRC_BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int OFFSET   = EXT_BIAS - SRC_BIAS;
    localparam int PAD_W    = FRAC_AL_W - FRAC_W;

    logic [EXP_W-1:0]  exp_field;
    logic [FRAC_W-1:0] frac_field;

    assign exp_field  = raw[EXP_W+FRAC_W-1:FRAC_W];
    assign frac_field = raw[FRAC_W-1:0];

    always_comb begin
        fields.sign         = raw[EXP_W+FRAC_W];
        fields.exp_all_ones = &exp_field;
        fields.exp_is_zero  = ~|exp_field;
        fields.frac_nonzero = |frac_field;
        fields.exp_rebiased = rebias(EXT_EXP_W'(exp_field), OFFSET);
        fields.frac_aligned = {frac_field, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/fext_assemble.sv
module fext_assemble
    import fext_pkg::*;
(
    input  src_fields_t fields,
    output ext_word_t   word
);
    always_comb begin
        word.sign = fields.sign;
        if (fields.exp_all_ones) begin
            word.exponent = EXT_EXP_SPECIAL;
            word.mantissa = {1'b1, fields.frac_aligned};
            word.denorm   = 1'b0;
        end else if (fields.exp_is_zero) begin
            word.exponent = '0;
            word.mantissa = {1'b0, fields.frac_aligned};
            word.denorm   = fields.frac_nonzero;
        end else begin
            word.exponent = fields.exp_rebiased;
            word.mantissa = {1'b1, fields.frac_aligned};
            word.denorm   = 1'b0;
        end
    end
endmodule

// File: rtl/fext_convert.sv
module fext_convert
    import fext_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_fmt,
    input  logic [SRC_W-1:0]     in_word,
    output logic                 out_valid,
    output logic                 out_sign,
    output logic [EXT_EXP_W-1:0] out_exp,
    output logic [EXT_MAN_W-1:0] out_man,
    output logic                 out_denorm
);
    src_fields_t fields_by_fmt [NUM_FMT];
    ext_word_t   word_by_fmt   [NUM_FMT];
    ext_word_t   result_d;
    ext_word_t   result_q;
    logic        valid_q;

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int EW = fmt_exp_w(g);
        localparam int FW = fmt_frac_w(g);

        fext_unpack #(.EXP_W(EW), .FRAC_W(FW)) i_unpack (
            .raw    (in_word[EW+FW:0]),
            .fields (fields_by_fmt[g])
        );

        fext_assemble i_assemble (
            .fields (fields_by_fmt[g]),
            .word   (word_by_fmt[g])
        );
    end

    always_comb begin
        result_d = (src_fmt_e'(in_fmt) == FMT_BIN64) ? word_by_fmt[1] : word_by_fmt[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            result_q <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                result_q <= result_d;
            end
        end
    end

    assign out_valid  = valid_q;
    assign out_sign   = result_q.sign;
    assign out_exp    = result_q.exponent;
    assign out_man    = result_q.mantissa;
    assign out_denorm = result_q.denorm;

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    assert_int_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_denorm && out_exp != '0) |-> out_man[EXT_MAN_W-1]);

    assert_special_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_exp == EXT_EXP_SPECIAL) |-> (out_man[EXT_MAN_W-1] && !out_denorm));

    assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_exp == '0 && !out_denorm) |-> (out_man == '0));

    assert_denorm_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_denorm) |-> (!out_man[EXT_MAN_W-1] && out_exp == '0 && out_man != '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |->
            ($stable(out_man) && $stable(out_exp) && $stable(out_sign) && $stable(out_denorm)));
endmodule

// File: tb/test_fext_convert.sv
`timescale 1ns/1ps
module test_fext_convert;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_fmt;
    logic [63:0] in_word;
    logic        out_valid;
    logic        out_sign;
    logic [14:0] out_exp;
    logic [63:0] out_man;
    logic        out_denorm;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference state
    logic        m_valid, m_sign, m_denorm;
    logic [14:0] m_exp;
    logic [63:0] m_man;

    always #2.5 clk = ~clk;

    fext_convert i_fext_convert (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt), .in_word(in_word),
        .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
        .out_man(out_man), .out_denorm(out_denorm)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural model of one conversion
    task automatic model(logic fmt, logic [63:0] w);
        longint unsigned e, f, emax, off;
        int fw;
        if (fmt) begin
            m_sign = w[63]; e = w[62:52]; f = w[51:0]; fw = 52; emax = 2047; off = 16383 - 1023;
        end else begin
            m_sign = w[31]; e = w[30:23]; f = w[22:0]; fw = 23; emax = 255; off = 16383 - 127;
        end
        m_man = 64'(f) << (63 - fw);
        m_denorm = 1'b0;
        if (e == emax) begin
            m_exp = 15'h7FFF; m_man[63] = 1'b1;
        end else if (e == 0) begin
            m_exp = 15'd0; m_denorm = (f != 0);
        end else begin
            m_exp = 15'(e + off); m_man[63] = 1'b1;
        end
    endtask

    task automatic step(string req, logic v, logic fmt, logic [63:0] w);
        in_valid = v; in_fmt = fmt; in_word = w;
        @(posedge clk);
        m_valid = v;
        if (v) model(fmt, w);
        @(negedge clk);
        #0.5;
        check(req, "valid", 64'(out_valid), 64'(m_valid));
        check(req, "sign", 64'(out_sign), 64'(m_sign));
        check(req, "exp", 64'(out_exp), 64'(m_exp));
        check(req, "man", out_man, m_man);
        check(req, "denorm", 64'(out_denorm), 64'(m_denorm));
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_fmt = 1'b0; in_word = '0;
        m_valid = 0; m_sign = 0; m_denorm = 0; m_exp = '0; m_man = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check("R8", "valid", 64'(out_valid), 64'd0);
        check("R8", "exp", 64'(out_exp), 64'd0);
        check("R8", "man", out_man, 64'd0);
        check("R8", "denorm", 64'(out_denorm), 64'd0);
        rst = 1'b0;

        // R3: 1.0 and -2.5 in binary32, with literal cross-checks
        step("R3", 1, 0, 64'h0000_0000_3F80_0000);
        check("R3", "exp lit", 64'(out_exp), 64'd16383);
        check("R3", "man lit", out_man, 64'h8000_0000_0000_0000);
        step("R3", 1, 0, 64'h0000_0000_C020_0000);
        check("R3", "man lit", out_man, 64'hA000_0000_0000_0000);
        // R2: upper half ignored for binary32
        step("R2", 1, 0, 64'hDEAD_BEEF_3F80_0000);
        check("R2", "exp lit", 64'(out_exp), 64'd16383);
        step("R2", 1, 0, 64'hFFFF_FFFF_0012_3456);
        step("R2", 1, 0, 64'h0000_0000_7F7F_FFFF);
        // R5: binary32 infinity and NaN
        step("R5", 1, 0, 64'h0000_0000_7F80_0000);
        step("R5", 1, 0, 64'h0000_0000_FFC0_0001);
        // R6: binary32 zeros
        step("R6", 1, 0, 64'h0000_0000_0000_0000);
        step("R6", 1, 0, 64'h1234_5678_8000_0000);
        // R7: binary32 subnormals
        step("R7", 1, 0, 64'h0000_0000_0000_0001);
        check("R7", "man lit", out_man, 64'h0000_0100_0000_0000);
        step("R7", 1, 0, 64'h0000_0000_807F_FFFF);
        // R4: binary64 normals
        step("R4", 1, 1, 64'h3FF0_0000_0000_0000);
        check("R4", "exp lit", 64'(out_exp), 64'd16383);
        step("R4", 1, 1, 64'hBFB9_9999_9999_999A);
        step("R4", 1, 1, 64'h7FEF_FFFF_FFFF_FFFF);
        step("R4", 1, 1, 64'h0010_0000_0000_0000);
        // R5: binary64 infinity and NaN
        step("R5", 1, 1, 64'hFFF0_0000_0000_0000);
        check("R5", "exp lit", 64'(out_exp), 64'h7FFF);
        step("R5", 1, 1, 64'h7FF8_0000_0000_0ABC);
        // R6 / R7: binary64 zero and subnormal
        step("R6", 1, 1, 64'h8000_0000_0000_0000);
        step("R7", 1, 1, 64'h000F_FFFF_FFFF_FFFF);
        check("R7", "denorm lit", 64'(out_denorm), 64'd1);
        // R9: idle cycles with changing inputs
        step("R9", 0, 1, 64'h3FF0_0000_0000_0000);
        step("R9", 0, 0, 64'h0000_0000_7F80_0000);
        step("R9", 0, 1, 64'h0000_0000_0000_0001);
        // R1: back-to-back then gap then single request
        step("R1", 1, 0, 64'h0000_0000_4049_0FDB);
        step("R1", 1, 1, 64'h4009_21FB_5444_2D18);
        step("R1", 0, 0, 64'h0);
        step("R1", 1, 1, 64'hC000_0000_0000_0000);
        step("R1", 0, 1, 64'h0);
        // R8: reset mid-stream clears outputs
        rst = 1'b1; in_valid = 1'b1; in_word = 64'h3FF0_0000_0000_0000; in_fmt = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R8", "valid", 64'(out_valid), 64'd0);
        check("R8", "man", out_man, 64'd0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule